// File: doc/BRIEF.md
# Serial Frame Buffer Loader

This block turns a stream of received bytes into the contents of a display frame buffer. The buffer is organised as 40 rows of 5 bytes, and a display scanner reads it through its own port. Each ordinary byte is stored at the current write position. The position then moves one byte along the row. At the end of a row it moves to the start of the next row, and after the last row it returns to row 0 without any notice.

One reserved byte value, 0x1B, serves as the only framing mark. It is never stored. Instead it sends the write position back to row 0, byte 0, so a sender can realign a full frame at any moment.

After reset the block clears every byte of the buffer, one address per cycle. While it does so, it holds its input off through a ready signal. The scanner reads the buffer through a synchronous port with one cycle of latency.

Top module: `serial_fb_loader`

## Requirements
- R1: After the clear that follows reset, every buffer address reads back as 0x00.
- R2: After reset is released, `in_ready` stays low for exactly ROWS*COLS (200) cycles and then stays high. A byte presented while `in_ready` is low is neither stored nor counted.
- R3: A byte is taken only on a clock edge where `in_valid` and `in_ready` are both high, and at most one byte is taken per edge. While `in_valid` is low the write position does not move.
- R4: A taken byte other than 0x1B is written to row r, byte c, at linear read address r*5+c. The byte position then advances by one.
- R5: When byte position 4 is written, the position goes to byte 0 of the next row. Row 39 is followed by row 0, so the 201st stored byte overwrites address 0.
- R6: A taken 0x1B byte changes no buffer location and returns the write position to row 0, byte 0.
- R7: `rd_data` shows the byte at `rd_addr` on the edge after the edge that samples `rd_en` high. It keeps its value while `rd_en` is low.
- R8: If a read and a write target the same address on the same edge, the read returns the data held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Loader can take a byte this cycle |
| rd_en | input | 1 | Scanner read request |
| rd_addr | input | 8 | Scanner read address, row*5+byte |
| rd_data | output | 8 | Read data, one cycle after the request |

## Verification
The assertions assume that `in_data` is stable wherever `in_valid` is high. They also assume the scanner keeps `rd_addr` below ROWS*COLS whenever `rd_en` is high, because an out-of-range read has no defined result. The stimulus drives every input on the falling edge and takes its read addresses only from the range 0..199. Random traffic holds `in_valid` high with ready-independent gaps, and about one byte in eight is the escape value, so that realignment happens at arbitrary positions.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
   typedef logic [7:0] byte_t;
   localparam byte_t DEFAULT_ESC = 8'h1B;
endpackage

// File: rtl/fbl_clear_seq.sv
module fbl_clear_seq #(
   parameter int DEPTH  = 200,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              busy,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fbl_clear_seq: DEPTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         addr <= '0;
      end else if (busy) begin
         if (addr == LAST) begin
            busy <= 1'b0;
            addr <= '0;
         end else begin
            addr <= addr + ADDR_W'(1);
         end
      end
   end

   AST_CLEAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy); // R2
   AST_CLEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr != LAST) |=> (busy && addr == $past(addr) + ADDR_W'(1))); // R2
endmodule

// File: rtl/fbl_wr_ptr.sv
module fbl_wr_ptr
   import fbl_pkg::*;
#(
   parameter int    ROWS   = 40,
   parameter int    COLS   = 5,
   parameter byte_t ESC    = DEFAULT_ESC,
   parameter int    ADDR_W = $clog2(ROWS * COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  byte_t             data,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output byte_t             wdata
);
   localparam int ROW_W = $clog2(ROWS);
   localparam int COL_W = $clog2(COLS);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
   localparam bit COLS_POW2 = ((1 << COL_W) == COLS);

   logic [ROW_W-1:0] row;
   logic [COL_W-1:0] col;
   logic             is_esc;

   assign is_esc = (data == ESC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
         col <= '0;
      end else if (take) begin
         if (is_esc) begin
            row <= '0;
            col <= '0;
         end else if (col == LAST_COL) begin
            col <= '0;
            row <= (row == LAST_ROW) ? '0 : row + ROW_W'(1);
         end else begin
            col <= col + COL_W'(1);
         end
      end
   end

   assign we    = take && !is_esc;
   assign wdata = data;

   generate
      if (COLS_POW2) begin : g_addr_concat
         assign waddr = ADDR_W'({row, col});
      end else begin : g_addr_mac
         assign waddr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);
      end
   endgenerate

   AST_ESC_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_esc) |=> (row == '0 && col == '0)); // R6
   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !is_esc && col != LAST_COL) |=>
         (col == $past(col) + COL_W'(1) && row == $past(row))); // R4
   AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !is_esc && col == LAST_COL && row == LAST_ROW) |=>
         (row == '0 && col == '0)); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(row) && $stable(col))); // R3
   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(row) < ROWS && int'(col) < COLS)); // R5
endmodule

// File: rtl/fbl_dpram.sv
module fbl_dpram
   import fbl_pkg::*;
#(
   parameter int DEPTH  = 200,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  byte_t             wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output byte_t             rdata
);
   byte_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata)); // R7
endmodule

// File: rtl/serial_fb_loader.sv
module serial_fb_loader
   import fbl_pkg::*;
#(
   parameter int    ROWS = 40,
   parameter int    COLS = 5,
   parameter byte_t ESC  = DEFAULT_ESC,
   parameter int    DEPTH  = ROWS * COLS,
   parameter int    ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("serial_fb_loader: ROWS must be at least 2");
      end
      if (COLS < 2) begin : g_bad_cols
         $error("serial_fb_loader: COLS must be at least 2");
      end
      if (DEPTH != ROWS * COLS) begin : g_bad_depth
         $error("serial_fb_loader: DEPTH must equal ROWS*COLS");
      end
   endgenerate

   logic              clr_busy;
   logic [ADDR_W-1:0] clr_addr;
   logic              ptr_we;
   logic [ADDR_W-1:0] ptr_addr;
   byte_t             ptr_wdata;
   logic              take;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   byte_t             mem_wdata;

   assign in_ready = !clr_busy;
   assign take     = in_valid && in_ready;

   fbl_clear_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_clear (
      .clk  (clk),
      .rst_n(rst_n),
      .busy (clr_busy),
      .addr (clr_addr)
   );

   fbl_wr_ptr #(.ROWS(ROWS), .COLS(COLS), .ESC(ESC), .ADDR_W(ADDR_W)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .take (take),
      .data (in_data),
      .we   (ptr_we),
      .waddr(ptr_addr),
      .wdata(ptr_wdata)
   );

   assign mem_we    = clr_busy || ptr_we;
   assign mem_waddr = clr_busy ? clr_addr : ptr_addr;
   assign mem_wdata = clr_busy ? '0 : ptr_wdata;

   fbl_dpram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata),
      .re   (rd_en),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy |-> !in_ready); // R2
   AST_NO_ESC_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_we && !clr_busy) |-> (ptr_wdata != ESC)); // R6
   AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (int'(mem_waddr) < DEPTH)); // R4
endmodule

// File: tb/test_serial_fb_loader.sv
`timescale 1ns/1ps
module test_serial_fb_loader;
   localparam int ROWS = 40;
   localparam int COLS = 5;
   localparam int DEPTH = ROWS * COLS;
   localparam logic [7:0] ESC = 8'h1B;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready;
   logic       rd_en = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int fails = 0;
   logic [7:0] model [DEPTH];
   int mrow = 0;
   int mcol = 0;

   always #4 clk = ~clk;

   serial_fb_loader i_serial_fb_loader (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int cur_addr();
      return mrow * COLS + mcol;
   endfunction

   function automatic void model_take(input logic [7:0] d);
      if (d == ESC) begin
         mrow = 0;
         mcol = 0;
      end else begin
         model[cur_addr()] = d;
         mcol++;
         if (mcol == COLS) begin
            mcol = 0;
            mrow = (mrow == ROWS - 1) ? 0 : mrow + 1;
         end
      end
   endfunction

   task automatic send(input logic [7:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      @(posedge clk);
      model_take(d);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h77;
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      @(negedge clk);
      in_valid = 1'b0;
      rd_en    = 1'b1;
      rd_addr  = 8'(a);
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic dump(input string req);
      logic [7:0] v;
      for (int a = 0; a < DEPTH; a++) begin
         rd(a, v);
         chk(req, int'(v), int'(model[a]));
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] v;
      logic [7:0] old;
      int cnt;
      void'($urandom(32'd4711));
      for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;

      // R2: reset state, hold-off length, bytes during clear ignored
      repeat (3) @(negedge clk);
      chk("R2 ready low in reset", int'(in_ready), 0);
      in_valid = 1'b1;
      in_data  = 8'hA5;
      rst_n    = 1'b1;
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!in_ready && cnt < 1000);
      in_valid = 1'b0;
      chk("R2 hold-off cycles", cnt, DEPTH);
      idle(2);
      chk("R2 ready stays high", int'(in_ready), 1);

      // R1: cleared buffer (and R2: A5 never stored)
      dump("R1");

      // R4: directed row-major stores
      for (int i = 0; i < 7; i++) send(8'(8'h10 + i));
      idle(1);
      dump("R4");

      // R6: escape realigns without storing
      send(ESC);
      send(8'hC1);
      send(8'hC2);
      idle(1);
      rd(0, v); chk("R6 addr0", int'(v), 8'hC1);
      rd(2, v); chk("R6 addr2 kept", int'(v), 8'h12);
      send(ESC);
      send(ESC);
      idle(1);
      dump("R6");

      // R5: full wrap, 203 bytes
      for (int i = 0; i < DEPTH + 3; i++) send(8'(i + 1) == ESC ? 8'h00 : 8'(i + 1));
      idle(1);
      rd(0, v); chk("R5 wrap addr0", int'(v), 8'hC9);
      rd(4, v); chk("R5 row boundary", int'(v), 8'h05);
      rd(5, v); chk("R5 next row", int'(v), 8'h06);
      dump("R5");

      // R3: garbage with valid low does not move the pointer
      idle(5);
      send(8'h5A);
      idle(1);
      rd(3, v); chk("R3 pointer held", int'(v), 8'h5A);

      // R8: same-address read during write returns old data
      old = model[cur_addr()];
      cnt = cur_addr();
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'hE7;
      rd_en    = 1'b1;
      rd_addr  = 8'(cnt);
      @(posedge clk);
      model_take(8'hE7);
      @(negedge clk);
      in_valid = 1'b0;
      rd_en    = 1'b0;
      chk("R8 old data", int'(rd_data), int'(old));
      rd(cnt, v); chk("R8 new data after", int'(v), 8'hE7);

      // R7: one-cycle latency and hold while rd_en low
      rd(cnt, v);
      @(negedge clk);
      rd_addr = 8'(cnt + 1);
      repeat (2) @(negedge clk);
      chk("R7 hold", int'(rd_data), 8'hE7);
      @(negedge clk);
      rd_en = 1'b1;
      rd_addr = 8'(cnt + 1);
      @(negedge clk);
      rd_en = 1'b0;
      chk("R7 latency", int'(rd_data), int'(model[cnt + 1]));

      // Random traffic with escapes and gaps
      for (int i = 0; i < 700; i++) begin
         logic [7:0] d;
         d = ($urandom % 8 == 0) ? ESC : 8'($urandom);
         if ($urandom % 4 == 0) idle(1 + $urandom % 3);
         send(d);
      end
      idle(1);
      dump("R4 random");

      summary();
   end
endmodule